// File: doc/BRIEF.md
# Two-Stream Burst Round-Robin Arbiter

This block decides which of two memory-to-memory transfer streams may use the bus in each cycle. A programmable period value sets the policy. When the period is zero, the block uses strict fixed priority, and stream 0 always wins. When the period is nonzero, the two streams take turns. Each turn is a burst of at most the programmed number of completed transfers.

In round-robin mode, a selection is either free or locked. On a free cycle that has no higher-precedence traffic, a requesting stream is granted and the selection locks to it. At that moment a burst counter is loaded with the period. The counter then counts down once for every completed word write. The lock ends in either of two cases: the count runs out, or the holder withdraws its request. When the lock ends, the other stream gets precedence. A busy input from higher-precedence traffic blocks any grant while it is high. The remaining count is shown on a status output.

Top module: `dual_stream_rr_arb`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `gnt` is 2'b00 and `burst_left` is 0. The selection starts free and stream 0 holds precedence.
- R2: When `period` is 0 and the selection is free, `gnt` in the next cycle is 2'b01 if `req[0]` is high. It is 2'b10 if only `req[1]` is high. It is 2'b00 if neither is high. No lock is taken and `burst_left` stays 0.
- R3: A cycle with `hp_busy` high produces `gnt` = 2'b00 in the following cycle.
- R4: At most one bit of `gnt` (bit 0 = stream 0, bit 1 = stream 1) is set in any cycle.
- R5: With a nonzero period P and a free selection, a free cycle with requests locks to one stream. Stream 0 wins if both request, unless precedence has passed to stream 1. The next cycle shows that stream's grant and `burst_left` = P.
- R6: While locked, each cycle with `xfer_done` high lowers `burst_left` by one in the next cycle. This also applies in cycles blocked by `hp_busy`.
- R7: A `xfer_done` that brings the count from 1 to 0 releases the lock. Precedence passes to the other stream, and a new lock may be taken on the same edge.
- R8: If the locked stream drops its request, the lock is released on that edge with precedence passed to the other stream. A requesting other stream is granted in the next cycle.
- R9: A change to `period` while locked leaves `burst_left` untouched. The new value is loaded only at the next lock.
- R10: A lock survives `hp_busy` cycles. The grant to the same stream reappears in the cycle after `hp_busy` falls.
- R11: A stream's grant bit is set only if that stream's request was high in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 2 | Request per stream, bit i for stream i |
| xfer_done | input | 1 | One word of the current transfer written to memory |
| hp_busy | input | 1 | Higher-precedence traffic owns this cycle |
| period | input | CNT_W | Burst length; 0 selects fixed priority |
| gnt | output | 2 | Registered one-hot grant |
| burst_left | output | CNT_W | Transfers left in the current burst |

## Verification
Every result is registered once. A grant and a count both reflect the inputs sampled at the edge just before, so each is due exactly one cycle after its stimulus. The bench changes inputs on the falling edge. A behavioural model advances on the same rising edge as the design, and the bench compares `gnt` and `burst_left` at the next falling edge. Directed sequences then check exact one-cycle-later values at each lock, countdown, release, busy and period-change step before a long random run.

// File: rtl/arb_rr_pkg.sv
package arb_rr_pkg;
  typedef enum logic {
    SEL_FREE   = 1'b0,
    SEL_LOCKED = 1'b1
  } sel_state_e;

  function automatic logic [1:0] stream_onehot(input logic s);
    return {s, ~s};
  endfunction
endpackage

// File: rtl/rr_winner_pick.sv
module rr_winner_pick (
  input  logic [1:0] req,
  input  logic       prefer,
  input  logic       fixed_mode,
  output logic       any_req,
  output logic       winner
);
  always_comb begin
    any_req = |req;
    if (req == 2'b11)
      winner = fixed_mode ? 1'b0 : prefer;
    else
      winner = req[1] & ~req[0];
  end
endmodule

// File: rtl/rr_burst_counter.sv
module rr_burst_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             clear,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt,
  output logic             last_one
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign last_one = dec && (cnt == ONE);

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_val;
    else if (clear)
      cnt <= '0;
    else if (dec && cnt != '0)
      cnt <= cnt - ONE;
  end
endmodule

// File: rtl/dual_stream_rr_arb.sv
module dual_stream_rr_arb #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       req,
  input  logic             xfer_done,
  input  logic             hp_busy,
  input  logic [CNT_W-1:0] period,
  output logic [1:0]       gnt,
  output logic [CNT_W-1:0] burst_left
);
  import arb_rr_pkg::*;

  sel_state_e sel_q;
  logic       owner_q;
  logic       prefer_q;

  logic       locked;
  logic       exhaust;
  logic       hold;
  logic       release_now;
  logic       prefer_eff;
  logic       fixed_mode;
  logic       any_req;
  logic       winner;
  logic       new_grant;
  logic       lock_now;
  logic [1:0] gnt_d;

  assign locked      = (sel_q == SEL_LOCKED);
  assign fixed_mode  = (period == '0);
  assign hold        = locked && req[owner_q] && !exhaust;
  assign release_now = locked && !hold;
  assign prefer_eff  = release_now ? ~owner_q : prefer_q;
  assign new_grant   = !hold && !hp_busy && any_req;
  assign lock_now    = new_grant && !fixed_mode;

  rr_winner_pick u_pick (
    .req        (req),
    .prefer     (prefer_eff),
    .fixed_mode (fixed_mode),
    .any_req    (any_req),
    .winner     (winner)
  );

  rr_burst_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .load     (lock_now),
    .load_val (period),
    .clear    (release_now),
    .dec      (locked && xfer_done),
    .cnt      (burst_left),
    .last_one (exhaust)
  );

  always_comb begin
    if (hold)
      gnt_d = hp_busy ? 2'b00 : stream_onehot(owner_q);
    else if (new_grant)
      gnt_d = stream_onehot(winner);
    else
      gnt_d = 2'b00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q    <= SEL_FREE;
      owner_q  <= 1'b0;
      prefer_q <= 1'b0;
      gnt      <= 2'b00;
    end else begin
      gnt <= gnt_d;
      if (release_now)
        prefer_q <= ~owner_q;
      if (lock_now) begin
        sel_q   <= SEL_LOCKED;
        owner_q <= winner;
      end else if (release_now) begin
        sel_q <= SEL_FREE;
      end
    end
  end
endmodule

// File: rtl/dual_stream_rr_arb_chk.sv
module dual_stream_rr_arb_chk #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       req,
  input logic             xfer_done,
  input logic             hp_busy,
  input logic [CNT_W-1:0] period,
  input logic [1:0]       gnt,
  input logic [CNT_W-1:0] burst_left
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  p_idle_after_reset_r1: assert property (@(posedge clk)
    $fell(rst) |-> (gnt == 2'b00 && burst_left == '0));

  p_fixed_stream0_r2: assert property (@(posedge clk) disable iff (rst)
    (period == '0 && burst_left == '0 && req[0] && !hp_busy) |=> gnt == 2'b01);

  p_busy_blocks_r3: assert property (@(posedge clk) disable iff (rst)
    hp_busy |=> gnt == 2'b00);

  p_single_grant_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  p_countdown_r6: assert property (@(posedge clk) disable iff (rst)
    (burst_left > ONE && xfer_done && (gnt & req) != 2'b00)
      |=> burst_left == $past(burst_left) - ONE);

  for (genvar i = 0; i < 2; i++) begin : g_req_gate
    p_grant_needs_req_r11: assert property (@(posedge clk) disable iff (rst)
      gnt[i] |-> $past(req[i]));
  end
endmodule

bind dual_stream_rr_arb dual_stream_rr_arb_chk #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .req        (req),
  .xfer_done  (xfer_done),
  .hp_busy    (hp_busy),
  .period     (period),
  .gnt        (gnt),
  .burst_left (burst_left)
);

// File: tb/test_dual_stream_rr_arb.sv
module test_dual_stream_rr_arb;
  localparam int CNT_W = 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [1:0]       req = 2'b00;
  logic             xfer_done = 1'b0;
  logic             hp_busy = 1'b0;
  logic [CNT_W-1:0] period = '0;
  logic [1:0]       gnt;
  logic [CNT_W-1:0] burst_left;

  int n_cmp = 0;
  int n_bad = 0;
  string phase = "R1";

  // behavioural reference state
  int m_locked, m_owner, m_cnt, m_pref, m_gnt;

  always #4 clk = ~clk;

  dual_stream_rr_arb #(.CNT_W(CNT_W)) i_dual_stream_rr_arb (
    .clk(clk), .rst(rst), .req(req), .xfer_done(xfer_done),
    .hp_busy(hp_busy), .period(period), .gnt(gnt), .burst_left(burst_left)
  );

  always @(posedge clk) begin
    if (rst) begin
      m_locked = 0; m_owner = 0; m_cnt = 0; m_pref = 0; m_gnt = 0;
    end else begin
      int still;
      int pick;
      int p;
      p = int'(period);
      still = 0;
      if (m_locked != 0) begin
        if (xfer_done) m_cnt = m_cnt - 1;
        if (req[m_owner] && m_cnt > 0) still = 1;
        else begin
          m_locked = 0;
          m_pref = 1 - m_owner;
          m_cnt = 0;
        end
      end
      if (still != 0) begin
        m_gnt = hp_busy ? 0 : (1 << m_owner);
      end else if (!hp_busy && req != 2'b00) begin
        if (req == 2'b11) pick = (p == 0) ? 0 : m_pref;
        else pick = req[1] ? 1 : 0;
        m_gnt = 1 << pick;
        if (p != 0) begin
          m_locked = 1; m_owner = pick; m_cnt = p;
        end
      end else begin
        m_gnt = 0;
      end
    end
  end

  task automatic check(input int eg, input int ec, input string tag);
    n_cmp++;
    if (int'(gnt) != eg || int'(burst_left) != ec) begin
      n_bad++;
      $display("FAIL %s: gnt=%0d burst_left=%0d expected gnt=%0d burst_left=%0d",
               tag, gnt, burst_left, eg, ec);
    end
  endtask

  task automatic step(input logic [1:0] r, input logic d, input logic b,
                      input int p);
    req = r; xfer_done = d; hp_busy = b; period = CNT_W'(p);
    @(negedge clk);
    check(m_gnt, m_cnt, {phase, " model"});
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(0, 0, "R1 in reset");
    rst = 1'b0;
    step(2'b00, 0, 0, 3); check(0, 0, "R1 after reset");
    phase = "R5";
    step(2'b11, 0, 0, 3); check(1, 3, "R5 first lock to stream 0");
    phase = "R6";
    step(2'b11, 1, 0, 3); check(1, 2, "R6 decrement");
    step(2'b11, 1, 0, 3); check(1, 1, "R6 decrement");
    phase = "R7";
    step(2'b11, 1, 0, 3); check(2, 3, "R7 exhaust hands to stream 1");
    phase = "R8";
    step(2'b01, 0, 0, 3); check(1, 3, "R8 drop hands to stream 0");
    phase = "R9";
    step(2'b01, 0, 0, 7); check(1, 3, "R9 period change ignored");
    step(2'b01, 1, 0, 7);
    step(2'b01, 1, 0, 7);
    step(2'b01, 1, 0, 7); check(1, 7, "R9 new period at relock");
    phase = "R10";
    step(2'b01, 0, 1, 7); check(0, 7, "R3 R10 busy blocks grant");
    step(2'b01, 1, 1, 7); check(0, 6, "R6 R10 count during busy");
    step(2'b01, 0, 0, 7); check(1, 6, "R10 lock resumes");
    phase = "R2";
    step(2'b00, 0, 0, 0); check(0, 0, "R2 release to idle");
    step(2'b11, 0, 0, 0); check(1, 0, "R2 fixed stream 0 wins");
    step(2'b11, 1, 0, 0); check(1, 0, "R2 fixed stream 0 keeps");
    step(2'b10, 0, 0, 0); check(2, 0, "R2 stream 1 when 0 idle");
    step(2'b11, 0, 1, 0); check(0, 0, "R3 busy in fixed mode");
    phase = "R4 R11 random";
    for (int k = 0; k < 4000; k++) begin
      int pp;
      pp = ($urandom_range(0, 3) == 0) ? 0 : $urandom_range(1, 6);
      step(2'($urandom), 1'($urandom), ($urandom_range(0, 4) == 0), pp);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule